// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block holds the status register and decides which writes are allowed for a serial nonvolatile memory with a 32K-byte array addressed by 15 bits. An upstream command decoder sends it single-cycle strobes: latch-arm, latch-disarm, status write (with a data byte), and array write (with a target address). It also receives the level of the active-low hardware protect pin and a status-read request. The block returns the status byte, and a registered grant or deny pulse for every write attempt. The serial shifter, the opcode decoder and the memory array sit outside it.

Protection has several layers. A write-enable latch must be armed before any write can succeed. A two-bit block-protect code fences off an upper region of the array. A protect-enable flag, together with the hardware pin, can freeze the status register itself. The nonvolatile flags are ordinary registers that load parameter values on reset.

The write-enable latch is a two-state machine. Its states are LATCH_SHUT and LATCH_OPEN. It has the following transitions:
- SHUT to OPEN on an arm strobe.
- OPEN to SHUT on a disarm strobe.
- OPEN to SHUT on a granted status write (the "sr-commit" transition).
- OPEN to SHUT on a granted array write (the "array-commit" transition).

Every other event leaves the state unchanged.

Top module: `sr_protect_ctrl`

## Requirements
- R1: The status byte carries protect-enable at bit 7, block-protect at bits 3:2 and the latch flag at bit 1. A read request returns the byte one cycle later with `sts_vld_o` high, sampled from the state in the request cycle.
- R2: Bits 6, 5, 4 and 0 of the status byte always read 0, whatever data a status write carried.
- R3: An arm strobe sets the latch and a disarm strobe clears it. Bit 1 of status-write data never changes the latch.
- R4: A granted status write and a granted array write both clear the latch.
- R5: A status write is granted only when the latch is set and not (protect-enable = 1 and `wp_n_i` = 0). A granted status write loads protect-enable from data bit 7 and block-protect from data bits 3:2.
- R6: With protect-enable at 0, the level of `wp_n_i` has no effect on any grant.
- R7: Block-protect code 00 protects nothing, 01 protects 6000h–7FFFh, 10 protects 4000h–7FFFh and 11 protects 0000h–7FFFh.
- R8: An array write is granted only when the latch is set and the address lies outside the protected range. Every array-write strobe yields exactly one of grant or deny.
- R9: A denied status write or array write leaves the latch, protect-enable and block-protect unchanged.
- R10: Reset clears the latch and all response outputs. Protect-enable and block-protect take the values of `INIT_WPEN` and `INIT_BP`.
- R11: Each grant or deny is a one-cycle pulse in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm write-enable latch strobe |
| disarm_i | input | 1 | Disarm write-enable latch strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_data_i | input | 8 | Status write data byte |
| mem_wr_i | input | 1 | Array write strobe |
| mem_addr_i | input | ADDR_W | Array write target address |
| wp_n_i | input | 1 | Hardware protect pin level, low = protect |
| sr_rd_i | input | 1 | Status read request |
| sts_byte_o | output | 8 | Captured status byte |
| sts_vld_o | output | 1 | Status byte valid pulse |
| mem_grant_o | output | 1 | Array write granted |
| mem_deny_o | output | 1 | Array write refused |
| sr_grant_o | output | 1 | Status write granted |
| sr_deny_o | output | 1 | Status write refused |

## Verification
The embedded assertions assume that at most one of the four write-type strobes (arm, disarm, status write, array write) is high in any cycle. A read request may coincide with any of them. Under that assumption, each response can be traced back to a single command. The stimulus respects this: every cycle it picks one command kind, or none, and drives only that strobe. It draws the read request, the pin level, the data byte and the address independently of the command choice. The directed phase walks each block-protect code across its boundary addresses before the random phase starts.

// File: rtl/sr_protect_pkg.sv
package sr_protect_pkg;

    localparam int SR_WPEN_BIT = 7;
    localparam int SR_BP_HI    = 3;
    localparam int SR_BP_LO    = 2;
    localparam int SR_WEL_BIT  = 1;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_code_e;

    typedef enum logic {
        LATCH_SHUT = 1'b0,
        LATCH_OPEN = 1'b1
    } latch_state_e;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_ARM    = 3'd1,
        CMD_DISARM = 3'd2,
        CMD_SRWR   = 3'd3,
        CMD_MEMWR  = 3'd4
    } cmd_e;

    function automatic logic [7:0] pack_status(input logic wpen,
                                               input logic [1:0] bp,
                                               input logic wel);
        logic [7:0] b;
        b = 8'h00;
        b[SR_WPEN_BIT]        = wpen;
        b[SR_BP_HI:SR_BP_LO]  = bp;
        b[SR_WEL_BIT]         = wel;
        return b;
    endfunction

endpackage

// File: rtl/sr_cmd_select.sv
module sr_cmd_select
    import sr_protect_pkg::*;
(
    input  logic arm_i,
    input  logic disarm_i,
    input  logic sr_wr_i,
    input  logic mem_wr_i,
    output cmd_e cmd_o
);
    // Fixed priority keeps behaviour defined if strobes ever overlap.
    always_comb begin
        if (sr_wr_i)
            cmd_o = CMD_SRWR;
        else if (mem_wr_i)
            cmd_o = CMD_MEMWR;
        else if (disarm_i)
            cmd_o = CMD_DISARM;
        else if (arm_i)
            cmd_o = CMD_ARM;
        else
            cmd_o = CMD_IDLE;
    end
endmodule

// File: rtl/sr_range_guard.sv
module sr_range_guard
    import sr_protect_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;
    localparam int SUB = ADDR_W - 2;

    logic unused_low;
    assign unused_low = ^addr_i[SUB-1:0];

    always_comb begin
        unique case (bp_code_e'(bp_i))
            BP_NONE:    hit_o = 1'b0;
            BP_QUARTER: hit_o = addr_i[TOP] & addr_i[SUB];
            BP_HALF:    hit_o = addr_i[TOP];
            BP_ALL:     hit_o = 1'b1;
            default:    hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_wel_fsm.sv
module sr_wel_fsm
    import sr_protect_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd_i,
    input  logic sr_ok_i,
    input  logic mem_ok_i,
    output logic wel_o
);
    latch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LATCH_SHUT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_SHUT: begin
                if (cmd_i == CMD_ARM)
                    state_d = LATCH_OPEN;
            end
            LATCH_OPEN: begin
                if (cmd_i == CMD_DISARM)
                    state_d = LATCH_SHUT;
                else if (cmd_i == CMD_SRWR && sr_ok_i)
                    state_d = LATCH_SHUT;
                else if (cmd_i == CMD_MEMWR && mem_ok_i)
                    state_d = LATCH_SHUT;
            end
            default: state_d = LATCH_SHUT;
        endcase
    end

    assign wel_o = (state_q == LATCH_OPEN);

    AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_ARM |=> wel_o); // R3
    AST_DISARM_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_DISARM |=> !wel_o); // R3
endmodule

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs
    import sr_protect_pkg::*;
#(
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BP   = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] data_i,
    output logic       wpen_o,
    output logic [1:0] bp_o
);
    logic unused_bits;
    assign unused_bits = ^{data_i[6:4], data_i[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpen_o <= INIT_WPEN;
            bp_o   <= INIT_BP;
        end else if (load_i) begin
            wpen_o <= data_i[SR_WPEN_BIT];
            bp_o   <= data_i[SR_BP_HI:SR_BP_LO];
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(wpen_o) && $stable(bp_o))); // R9
endmodule

// File: rtl/sr_protect_ctrl.sv
module sr_protect_ctrl
    import sr_protect_pkg::*;
#(
    parameter int         ADDR_W    = 15,
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BP   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              mem_wr_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              wp_n_i,
    input  logic              sr_rd_i,
    output logic [7:0]        sts_byte_o,
    output logic              sts_vld_o,
    output logic              mem_grant_o,
    output logic              mem_deny_o,
    output logic              sr_grant_o,
    output logic              sr_deny_o
);
    cmd_e       cmd;
    logic       wel;
    logic       wpen;
    logic [1:0] bp;
    logic       hit;
    logic       sr_ok;
    logic       mem_ok;
    logic       sr_commit;

    sr_cmd_select u_sel (
        .arm_i    (arm_i),
        .disarm_i (disarm_i),
        .sr_wr_i  (sr_wr_i),
        .mem_wr_i (mem_wr_i),
        .cmd_o    (cmd)
    );

    sr_range_guard #(.ADDR_W(ADDR_W)) u_range (
        .bp_i   (bp),
        .addr_i (mem_addr_i),
        .hit_o  (hit)
    );

    // Status register locked only when protect-enable is set and the pin is low.
    assign sr_ok     = wel && !(wpen && !wp_n_i);
    assign mem_ok    = wel && !hit;
    assign sr_commit = (cmd == CMD_SRWR) && sr_ok;

    sr_wel_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .sr_ok_i  (sr_ok),
        .mem_ok_i (mem_ok),
        .wel_o    (wel)
    );

    sr_cfg_regs #(.INIT_WPEN(INIT_WPEN), .INIT_BP(INIT_BP)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sr_commit),
        .data_i (sr_data_i),
        .wpen_o (wpen),
        .bp_o   (bp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_grant_o <= 1'b0;
            mem_deny_o  <= 1'b0;
            sr_grant_o  <= 1'b0;
            sr_deny_o   <= 1'b0;
            sts_vld_o   <= 1'b0;
            sts_byte_o  <= 8'h00;
        end else begin
            mem_grant_o <= (cmd == CMD_MEMWR) && mem_ok;
            mem_deny_o  <= (cmd == CMD_MEMWR) && !mem_ok;
            sr_grant_o  <= sr_commit;
            sr_deny_o   <= (cmd == CMD_SRWR) && !sr_ok;
            sts_vld_o   <= sr_rd_i;
            if (sr_rd_i)
                sts_byte_o <= pack_status(wpen, bp, wel);
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arm_i, disarm_i, sr_wr_i, mem_wr_i})); // R11
    AST_MEM_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_i |=> (mem_grant_o || mem_deny_o)); // R11
    AST_SR_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_i |=> (sr_grant_o || sr_deny_o)); // R11
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_grant_o, mem_deny_o})); // R8
    AST_MEM_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_i && !wel) |=> mem_deny_o); // R8
    AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_i && bp == BP_ALL) |=> !mem_grant_o); // R7
    AST_SR_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && wpen && !wp_n_i) |=> sr_deny_o); // R5
    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && !wpen && wel) |=> sr_grant_o); // R6
    AST_SR_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant_o |-> !wel); // R4
    AST_MEM_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_grant_o |-> !wel); // R4
    AST_DENY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_deny_o || mem_deny_o) |-> (wel == $past(wel) && wpen == $past(wpen)
                                       && bp == $past(bp))); // R9
    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        sts_vld_o |-> (sts_byte_o[6:4] == 3'b000 && !sts_byte_o[0])); // R2
    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant_o |=> !sr_grant_o); // R11
endmodule

// File: tb/tb_sr_protect_ctrl.sv
module tb_sr_protect_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_i = 0, disarm_i = 0, sr_wr_i = 0, mem_wr_i = 0;
    logic [7:0]    sr_data_i = 0;
    logic [AW-1:0] mem_addr_i = 0;
    logic          wp_n_i = 1, sr_rd_i = 0;
    logic [7:0]    sts_byte_o;
    logic          sts_vld_o, mem_grant_o, mem_deny_o, sr_grant_o, sr_deny_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state (R10: init values chosen away from zero)
    int   m_wel = 0, m_wpen = 1, m_bp = 1;
    logic e_mg = 0, e_md = 0, e_sg = 0, e_sd = 0, e_vld = 0;
    logic [7:0] e_sts = 8'h00;
    string cur_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_protect_ctrl #(.ADDR_W(AW), .INIT_WPEN(1'b1), .INIT_BP(2'b01)) dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
        .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .mem_wr_i(mem_wr_i),
        .mem_addr_i(mem_addr_i), .wp_n_i(wp_n_i), .sr_rd_i(sr_rd_i),
        .sts_byte_o(sts_byte_o), .sts_vld_o(sts_vld_o),
        .mem_grant_o(mem_grant_o), .mem_deny_o(mem_deny_o),
        .sr_grant_o(sr_grant_o), .sr_deny_o(sr_deny_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit in_range(input int bp, input int a);
        case (bp)
            0: return 0;
            1: return a >= 'h6000;
            2: return a >= 'h4000;
            default: return 1;
        endcase
    endfunction

    task automatic check_outputs();
        chk(cur_tag, "mem_grant", {7'd0, mem_grant_o}, {7'd0, e_mg});
        chk(cur_tag, "mem_deny",  {7'd0, mem_deny_o},  {7'd0, e_md});
        chk(cur_tag, "sr_grant",  {7'd0, sr_grant_o},  {7'd0, e_sg});
        chk(cur_tag, "sr_deny",   {7'd0, sr_deny_o},   {7'd0, e_sd});
        chk("R1", "sts_vld", {7'd0, sts_vld_o}, {7'd0, e_vld});
        if (e_vld) chk("R1", "sts_byte", sts_byte_o, e_sts);
    endtask

    // kind: 0 idle, 1 arm, 2 disarm, 3 status write, 4 array write
    task automatic step(input int kind, input logic [7:0] d, input int a,
                        input bit wp, input bit rd, input string tag);
        bit ok;
        @(negedge clk);
        check_outputs();
        cur_tag = tag;
        arm_i = (kind == 1); disarm_i = (kind == 2);
        sr_wr_i = (kind == 3); mem_wr_i = (kind == 4);
        sr_data_i = d; mem_addr_i = AW'(a); wp_n_i = wp; sr_rd_i = rd;
        e_vld = rd;
        if (rd) e_sts = {m_wpen[0], 3'b000, m_bp[1:0], m_wel[0], 1'b0};
        e_sg = 0; e_sd = 0; e_mg = 0; e_md = 0;
        case (kind)
            1: m_wel = 1;
            2: m_wel = 0;
            3: begin
                ok = (m_wel == 1) && !(m_wpen == 1 && !wp);
                e_sg = ok; e_sd = !ok;
                if (ok) begin m_wpen = d[7]; m_bp = d[3:2]; m_wel = 0; end
            end
            4: begin
                ok = (m_wel == 1) && !in_range(m_bp, a);
                e_mg = ok; e_md = !ok;
                if (ok) m_wel = 0;
            end
            default: ;
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: outputs low and init flags visible
        step(0, 0, 0, 1, 1, "R10");
        step(0, 0, 0, 1, 0, "R10");
        step(4, 0, 'h0000, 1, 0, "R8");       // latch shut: deny
        step(1, 0, 0, 1, 1, "R3");            // arm
        step(4, 0, 'h5FFF, 1, 1, "R7");       // quarter code: below edge granted
        step(1, 0, 0, 1, 0, "R3");
        step(4, 0, 'h6000, 1, 1, "R7");       // first protected address
        step(3, 8'h00, 0, 0, 1, "R5");        // pin low with protect-enable: deny, R9 latch kept
        step(3, 8'hFF, 0, 1, 1, "R2");        // granted, zero bits and latch bit ignored (R3, R4)
        step(1, 0, 0, 1, 1, "R4");
        step(4, 0, 'h0000, 1, 1, "R7");       // all protected
        step(3, 8'h08, 0, 1, 1, "R5");        // half code, protect-enable off
        step(1, 0, 0, 1, 0, "R3");
        step(4, 0, 'h3FFF, 1, 1, "R7");
        step(1, 0, 0, 1, 0, "R3");
        step(4, 0, 'h4000, 1, 1, "R7");
        step(3, 8'h00, 0, 0, 1, "R6");        // pin low ignored, code 00
        step(1, 0, 0, 0, 0, "R3");
        step(4, 0, 'h7FFF, 0, 1, "R6");       // nothing protected, pin low irrelevant
        step(1, 0, 0, 1, 0, "R3");
        step(2, 0, 0, 1, 1, "R3");            // disarm
        step(4, 0, 'h0100, 1, 1, "R9");
        step(0, 0, 0, 1, 1, "R11");
        for (int i = 0; i < 4000; i++) begin
            int k;
            string t;
            k = $urandom_range(0, 4);
            t = (k == 3) ? "R5" : (k == 4) ? "R8" : "R11";
            step(k, 8'($urandom), int'($urandom_range(0, 32767)),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) == 0), t);
        end
        step(0, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 0, "R11");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule